// File: doc/BRIEF.md
# Debounced Decimal Step Counter

This block keeps a six-digit decimal value in binary-coded decimal form. Three raw push-button inputs step the value. Each button is synchronised to the clock and filtered against contact bounce. Each filtered press then adds a fixed decimal weight: the first button adds one, the second adds ten and the third adds one hundred. Any carry out of a digit moves into the next higher digit in the same update. The value wraps to zero past its largest value.

Buttons are active-low. A button counts as pressed only after its synchronised level has stayed at the new value for a programmable number of clocks. Holding a button down, or letting it go, adds nothing more. The value appears on a packed digit bus, units in the lowest nibble. A one-clock flag marks each new value. An asynchronous active-low clear forces the value to zero at once. Display drive is left to logic outside the block.

Top module: `dec_step_counter`

## Requirements
- R1: While rst_n is low, every digit reads 0 and update_o is low. The clear acts at once, without waiting for a clock edge.
- R2: One accepted press of key_n[0] adds 1 to the value.
- R3: One accepted press of key_n[1] adds 10, and one accepted press of key_n[2] adds 100.
- R4: When a digit would pass 9, it drops by 10 and the next higher digit rises by one in the same update. Carries can chain through several digits.
- R5: The value wraps modulo 10^DIGITS, and only the low DIGITS digits are kept.
- R6: A key is pressed when its input is low (0). A press is accepted only after the synchronised level has held for STABLE_CYCLES clocks. Bursts of bounce shorter than that add nothing more than the one press.
- R7: A key held low gives exactly one increment, with no repeat. Releasing the key gives no increment.
- R8: Presses accepted on the same clock are summed into a single update, and none is lost.
- R9: update_o is high for exactly one clock each time the value changes. The digits stay unchanged whenever update_o is low.
- R10: Every 4-bit digit on digits_o always holds a value from 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| key_n | input | 3 | Raw active-low buttons; bit 0 adds 1, bit 1 adds 10, bit 2 adds 100 |
| digits_o | output | 4*DIGITS | BCD digits, units in bits 3:0, next higher digit in each following nibble |
| update_o | output | 1 | One-clock pulse with each new value |

## Verification
Single presses on each key separate the three weights. A run of nines followed by one more unit separates a correct chained carry from a carry that stops after one digit. A second instance with three digits is stepped to 999 and then past it, which shows whether the top carry is dropped. Bounce bursts around a press, a glitch shorter than the filter window, a long hold and a three-key press made together separate true debouncing from edge counting, and summed presses from lost ones.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
   // number of weighted keys; key k adds 10^k
   localparam int KEY_COUNT = 3;
   localparam int BCD_W     = 4;
   localparam logic [BCD_W-1:0] BCD_MAX = 4'd9;
endpackage

// File: rtl/dsc_key_filter.sv
module dsc_key_filter #(
   parameter int STABLE_CYCLES = 4_000_000,
   parameter int CNT_W         = $clog2(STABLE_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic key_n_i,
   output logic press_o
);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(STABLE_CYCLES - 1);

   generate
      if (STABLE_CYCLES < 1) begin : g_bad_stable
         $error("STABLE_CYCLES must be at least 1");
      end
   endgenerate

   logic [1:0]       sync_q;
   logic             level_q;   // 1 = released
   logic [CNT_W-1:0] cnt_q;
   logic             raw;

   assign raw = sync_q[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= 2'b11;
      end else begin
         sync_q <= {sync_q[0], key_n_i};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= 1'b1;
         cnt_q   <= '0;
         press_o <= 1'b0;
      end else begin
         press_o <= 1'b0;
         if (raw == level_q) begin
            cnt_q <= '0;
         end else if (cnt_q == LIMIT) begin
            level_q <= raw;
            cnt_q   <= '0;
            press_o <= ~raw;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/dsc_bcd_digit.sv
module dsc_bcd_digit
   import dsc_pkg::*;
(
   input  logic [BCD_W-1:0] d_i,
   input  logic             add_i,
   input  logic             cin_i,
   output logic [BCD_W-1:0] q_o,
   output logic             cout_o
);
   logic [BCD_W:0] sum;

   always_comb begin
      sum = {1'b0, d_i} + {{BCD_W{1'b0}}, add_i} + {{BCD_W{1'b0}}, cin_i};
      if (sum > {1'b0, BCD_MAX}) begin
         q_o    = BCD_W'(sum - 5'd10);
         cout_o = 1'b1;
      end else begin
         q_o    = sum[BCD_W-1:0];
         cout_o = 1'b0;
      end
   end
endmodule

// File: rtl/dsc_bcd_accum.sv
module dsc_bcd_accum
   import dsc_pkg::*;
#(
   parameter int DIGITS = 6,
   parameter int VAL_W  = DIGITS * BCD_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [KEY_COUNT-1:0] press_i,
   output logic [VAL_W-1:0]     value_o,
   output logic                 update_o
);
   logic [DIGITS-1:0] addend;
   logic [DIGITS:0]   carry;
   logic [VAL_W-1:0]  next_val;

   always_comb begin
      addend = '0;
      addend[KEY_COUNT-1:0] = press_i;
   end

   assign carry[0] = 1'b0;

   generate
      for (genvar i = 0; i < DIGITS; i++) begin : g_digit
         dsc_bcd_digit u_digit (
            .d_i    (value_o[i*BCD_W +: BCD_W]),
            .add_i  (addend[i]),
            .cin_i  (carry[i]),
            .q_o    (next_val[i*BCD_W +: BCD_W]),
            .cout_o (carry[i+1])
         );
      end
   endgenerate

   // carry[DIGITS] is dropped: modulo 10^DIGITS
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value_o  <= '0;
         update_o <= 1'b0;
      end else begin
         update_o <= |press_i;
         if (|press_i) value_o <= next_val;
      end
   end
endmodule

// File: rtl/dec_step_counter.sv
module dec_step_counter
   import dsc_pkg::*;
#(
   parameter int DIGITS        = 6,
   parameter int STABLE_CYCLES = 4_000_000
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [KEY_COUNT-1:0]      key_n,
   output logic [DIGITS*BCD_W-1:0]   digits_o,
   output logic                      update_o
);
   localparam int CNT_W = $clog2(STABLE_CYCLES + 1);

   generate
      if (DIGITS < KEY_COUNT) begin : g_bad_digits
         $error("DIGITS must cover every key weight");
      end
   endgenerate

   logic [KEY_COUNT-1:0] press_w;

   generate
      for (genvar k = 0; k < KEY_COUNT; k++) begin : g_key
         dsc_key_filter #(
            .STABLE_CYCLES (STABLE_CYCLES),
            .CNT_W         (CNT_W)
         ) u_filter (
            .clk     (clk),
            .rst_n   (rst_n),
            .key_n_i (key_n[k]),
            .press_o (press_w[k])
         );
      end
   endgenerate

   dsc_bcd_accum #(.DIGITS(DIGITS)) u_accum (
      .clk      (clk),
      .rst_n    (rst_n),
      .press_i  (press_w),
      .value_o  (digits_o),
      .update_o (update_o)
   );
endmodule

// File: rtl/dec_step_counter_chk.sv
module dec_step_counter_chk
   import dsc_pkg::*;
#(
   parameter int DIGITS = 6
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [DIGITS*BCD_W-1:0] digits_o,
   input logic                    update_o,
   input logic [KEY_COUNT-1:0]    press
);
   // R1
   always @(posedge clk) begin
      if (!rst_n) begin
         reset_zero_chk : assert (digits_o == '0 && !update_o);
      end
   end

   generate
      for (genvar i = 0; i < DIGITS; i++) begin : g_rng
         // R10
         digit_range_chk : assert property (@(posedge clk) disable iff (!rst_n)
            digits_o[i*BCD_W +: BCD_W] <= BCD_MAX);
      end
      for (genvar k = 0; k < KEY_COUNT; k++) begin : g_pls
         // R7
         press_single_chk : assert property (@(posedge clk) disable iff (!rst_n)
            press[k] |=> !press[k]);
      end
   endgenerate

   // R9
   update_change_chk : assert property (@(posedge clk) disable iff (!rst_n)
      update_o |-> digits_o != $past(digits_o));

   // R9
   hold_value_chk : assert property (@(posedge clk) disable iff (!rst_n)
      !update_o |-> $stable(digits_o));

   // R8
   update_cause_chk : assert property (@(posedge clk) disable iff (!rst_n)
      update_o |-> $past(|press));
endmodule

bind dec_step_counter dec_step_counter_chk #(.DIGITS(DIGITS)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .digits_o (digits_o),
   .update_o (update_o),
   .press    (press_w)
);

// File: tb/dec_step_counter_tb.sv
`timescale 1ns/1ps
module dec_step_counter_tb_top;
   localparam int STABLE = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  key_a_n = 3'b111;
   logic [2:0]  key_b_n = 3'b111;
   logic [23:0] dig_a;
   logic [11:0] dig_b;
   logic        upd_a, upd_b;
   int          checks = 0, fails = 0, upd_cnt = 0;
   int          exp_val = 0;
   bit          done = 0;

   always #2.5 clk = ~clk;

   dec_step_counter #(.DIGITS(6), .STABLE_CYCLES(STABLE)) dut_i (
      .clk(clk), .rst_n(rst_n), .key_n(key_a_n), .digits_o(dig_a), .update_o(upd_a));

   dec_step_counter #(.DIGITS(3), .STABLE_CYCLES(STABLE)) dut_b_i (
      .clk(clk), .rst_n(rst_n), .key_n(key_b_n), .digits_o(dig_b), .update_o(upd_b));

   always @(negedge clk) if (rst_n && upd_a) upd_cnt++;

   function automatic int val_of(input logic [23:0] d, input int n);
      int v = 0;
      for (int i = n - 1; i >= 0; i--) v = v * 10 + int'(d[i*4 +: 4]);
      return v;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_a(input string req);
      bit ok = 1;
      for (int i = 0; i < 6; i++) if (dig_a[i*4 +: 4] > 4'd9) ok = 0;
      check("R10 digit range", int'(ok), 1);
      check(req, val_of(dig_a, 6), exp_val);
   endtask

   task automatic press_a(input logic [2:0] mask, input int hold);
      @(negedge clk) key_a_n = ~mask;
      repeat (hold) @(negedge clk);
      key_a_n = 3'b111;
      repeat (STABLE + 12) @(negedge clk);
   endtask

   task automatic press_b(input logic [2:0] mask);
      @(negedge clk) key_b_n = ~mask;
      repeat (STABLE + 12) @(negedge clk);
      key_b_n = 3'b111;
      repeat (STABLE + 12) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      exp_val = 0;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 reset digits", val_of(dig_a, 6), 0);
      check("R1 reset update", int'(upd_a), 0);
   endtask

   task automatic t_units();
      int u0 = upd_cnt;
      for (int i = 0; i < 3; i++) press_a(3'b001, STABLE + 12);
      exp_val = 3;
      check_a("R2 add one");
      check("R9 one pulse per press", upd_cnt - u0, 3);
   endtask

   task automatic t_weights();
      press_a(3'b010, STABLE + 12); exp_val += 10;
      check_a("R3 add ten");
      press_a(3'b100, STABLE + 12); exp_val += 100;
      check_a("R3 add hundred");
   endtask

   task automatic t_carry();
      do_reset();
      for (int i = 0; i < 9; i++) press_a(3'b010, STABLE + 12);
      for (int i = 0; i < 9; i++) press_a(3'b001, STABLE + 12);
      exp_val = 99;
      check_a("R4 reach 99");
      press_a(3'b001, STABLE + 12); exp_val = 100;
      check_a("R4 chained carry");
   endtask

   task automatic t_bounce();
      int u0 = upd_cnt;
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         key_a_n[0] = 1'b0; repeat (3) @(negedge clk);
         key_a_n[0] = 1'b1; repeat (2) @(negedge clk);
      end
      key_a_n[0] = 1'b0; repeat (STABLE + 12) @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         key_a_n[0] = 1'b1; repeat (3) @(negedge clk);
         key_a_n[0] = 1'b0; repeat (2) @(negedge clk);
      end
      key_a_n[0] = 1'b1; repeat (STABLE + 12) @(negedge clk);
      exp_val += 1;
      check_a("R6 bounce gives one step");
      check("R6 bounce pulse count", upd_cnt - u0, 1);
      u0 = upd_cnt;
      press_a(3'b001, STABLE - 3);
      check_a("R6 short glitch ignored");
      check("R6 short glitch no pulse", upd_cnt - u0, 0);
   endtask

   task automatic t_hold();
      int u0 = upd_cnt;
      press_a(3'b100, 20 * STABLE); exp_val += 100;
      check_a("R7 hold no repeat");
      check("R7 hold pulse count", upd_cnt - u0, 1);
   endtask

   task automatic t_simul();
      int u0 = upd_cnt;
      press_a(3'b111, STABLE + 12); exp_val += 111;
      check_a("R8 simultaneous summed");
      check("R8 single update", upd_cnt - u0, 1);
   endtask

   task automatic t_wrap();
      for (int i = 0; i < 9; i++) press_b(3'b111);
      check("R5 reach 999", val_of({12'h0, dig_b}, 3), 999);
      press_b(3'b001);
      check("R5 wrap to zero", val_of({12'h0, dig_b}, 3), 0);
   endtask

   task automatic t_async_clear();
      check("R1 nonzero before clear", int'(val_of(dig_a, 6) != 0), 1);
      @(negedge clk); #0.5 rst_n = 1'b0;
      #0.5;
      check("R1 async clear", val_of(dig_a, 6), 0);
      @(negedge clk) rst_n = 1'b1;
      exp_val = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_units();
      t_weights();
      t_carry();
      t_bounce();
      t_hold();
      t_simul();
      t_wrap();
      t_async_clear();
      finish_run();
   end

   initial begin
      #(200000 * 5);
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end
endmodule